// File: doc/BRIEF.md
# Shared-Memory Mailbox with Ownership Handoff

This block is the device side of a 256-bit mailbox window that two agents share: a requester, which composes messages, and a responder, which answers them. The window is eight 32-bit dwords. Both sides can read every dword at any time through their own read ports.

Only the agent that currently owns the window may write. The requester fills dwords 0 to 6 with its payload. It then writes the header dword (index 7). That header write makes the hardware hand the window to the responder. The responder may rewrite only the header. When it writes a header whose top bit is clear, ownership goes back to the requester. Bit 31 of the header dword always shows the current owner on reads.

A separate function-reset input forces every read to return all ones. While it is asserted, the window is wiped and both sides are locked out.

Header fields that the agents use:
- message kind in bits [2:0]: 1 means establish, 2 means destroy
- version in bits [5:3]: 0
- direction in bit 7: 0 for a request, 1 for a response
- status in bits [15:8]: 0 in a request; in a response, 0 means success and any other value means failure
- reset request flag in bit 24
- owner in bit 31

The block itself decodes only bit 31.

Ownership is held in a three-state machine:
- `S_REQ_OWNS`: the requester owns the window, and bit 31 reads 0.
- `S_RSP_OWNS`: the responder owns the window, and bit 31 reads 1.
- `S_FN_RESET`: the function is in reset.

Its transitions are:
- HANDOVER, `S_REQ_OWNS` to `S_RSP_OWNS`: an accepted requester write to dword 7.
- RELEASE, `S_RSP_OWNS` to `S_REQ_OWNS`: an accepted responder write with bit 31 = 0.
- FN_ENTER, from any state to `S_FN_RESET`: `func_reset` is high at a clock edge.
- FN_EXIT, `S_FN_RESET` to `S_REQ_OWNS`: `func_reset` is low at a clock edge.

Top module: `mailbox_shm`

## Requirements
- R1: After `rst_n` is deasserted, all eight dwords read 0 on both read ports, and `rsp_owns` is 0 (the requester owns the window).
- R2: While the requester owns the window, a requester write to dword 0..6 stores the full 32-bit value. From the next clock edge, that value reads back on both ports.
- R3: While the requester owns the window, a requester write to dword 7 stores bits [30:0] and hands the window to the responder at the same edge. After that, dword 7 reads with bit 31 = 1 and `rsp_owns` = 1, whatever bit 31 of the written data was.
- R4: While the responder owns the window, requester writes to any dword leave the whole window unchanged, and ownership stays with the responder.
- R5: Responder writes made while the requester owns the window leave the window unchanged.
- R6: While the responder owns the window, a responder write with bit 31 = 0 stores bits [30:0] into dword 7. Ownership returns to the requester at the same clock edge, so dword 7 reads with bit 31 = 0.
- R7: While the responder owns the window, a responder write with bit 31 = 1 stores bits [30:0] into dword 7, and the responder keeps ownership.
- R8: Reads on both ports return 0xFFFFFFFF whenever `func_reset` is high. They also do so during the cycle after it falls, until the FN_EXIT edge. During that time, writes from either side are ignored.
- R9: After FN_EXIT, every dword reads 0, the requester owns the window, and requester writes are accepted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| func_reset | input | 1 | Function reset; forces all-ones reads and wipes the window |
| req_wr_en | input | 1 | Requester write strobe |
| req_wr_idx | input | 3 | Requester write dword index |
| req_wr_data | input | 32 | Requester write data |
| req_rd_idx | input | 3 | Requester read dword index |
| req_rd_data | output | 32 | Requester read data, combinational from index |
| rsp_wr_en | input | 1 | Responder header write strobe (targets dword 7) |
| rsp_wr_data | input | 32 | Responder header value; bit 31 = 0 releases ownership |
| rsp_rd_idx | input | 3 | Responder read dword index |
| rsp_rd_data | output | 32 | Responder read data, combinational from index |
| rsp_owns | output | 1 | 1 while the responder owns the window |

## Verification
The properties assume that `rst_n` is asserted once at start-up and that inputs change only away from the rising clock edge. The stimulus meets this by driving every input on the falling edge. The stability properties for ignored writes assume that the other side is not writing in the same cycle. The bench keeps most writes one-sided. Its single deliberate collision is checked only at the ports. The stimulus sweeps all 256 responder status values and three payload patterns across every data dword. Each value is checked against a model kept from the requirements.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Ownership states of the mailbox window.
    typedef enum logic [1:0] {
        S_REQ_OWNS = 2'd0,
        S_RSP_OWNS = 2'd1,
        S_FN_RESET = 2'd2
    } own_state_e;

    // Header field positions used by the agents (only the owner bit is
    // decoded in hardware, and it is always the top bit of the dword).
    localparam int unsigned HDR_KIND_LSB   = 0;
    localparam int unsigned HDR_VER_LSB    = 3;
    localparam int unsigned HDR_DIR_BIT    = 7;
    localparam int unsigned HDR_STATUS_LSB = 8;
    localparam int unsigned HDR_RSTREQ_BIT = 24;

endpackage

// File: rtl/mbx_own_fsm.sv
module mbx_own_fsm
    import mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       func_reset,
    input  logic       handover,
    input  logic       release_req,
    output own_state_e state,
    output logic       owner,
    output logic       in_reset,
    output logic       req_may_write,
    output logic       rsp_may_write
);

    own_state_e state_q;
    own_state_e state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_REQ_OWNS;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_REQ_OWNS: begin
                if (func_reset) begin
                    state_d = S_FN_RESET;      // FN_ENTER
                end else if (handover) begin
                    state_d = S_RSP_OWNS;      // HANDOVER
                end
            end
            S_RSP_OWNS: begin
                if (func_reset) begin
                    state_d = S_FN_RESET;      // FN_ENTER
                end else if (release_req) begin
                    state_d = S_REQ_OWNS;      // RELEASE
                end
            end
            S_FN_RESET: begin
                if (!func_reset) begin
                    state_d = S_REQ_OWNS;      // FN_EXIT
                end
            end
            default: state_d = S_FN_RESET;
        endcase
    end

    // Outputs.
    always_comb begin
        state         = state_q;
        owner         = (state_q == S_RSP_OWNS);
        in_reset      = func_reset || (state_q == S_FN_RESET);
        req_may_write = (state_q == S_REQ_OWNS) && !func_reset;
        rsp_may_write = (state_q == S_RSP_OWNS) && !func_reset;
    end

endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
    parameter int unsigned NUM_DW = 8,
    parameter int unsigned DW     = 32,
    localparam int unsigned IDX_W = $clog2(NUM_DW)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [DW-1:0]        wr_data,
    output logic [NUM_DW*DW-1:0] win_flat
);

    for (genvar g = 0; g < NUM_DW; g++) begin : g_dw
        logic [DW-1:0] dw_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dw_q <= '0;
            end else if (clr) begin
                dw_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                dw_q <= wr_data;
            end
        end

        assign win_flat[g*DW +: DW] = dw_q;
    end

endmodule

// File: rtl/mbx_rd_port.sv
module mbx_rd_port #(
    parameter int unsigned NUM_DW = 8,
    parameter int unsigned DW     = 32,
    localparam int unsigned IDX_W = $clog2(NUM_DW),
    localparam int unsigned HDR_IDX = NUM_DW - 1
) (
    input  logic [NUM_DW*DW-1:0] win_flat,
    input  logic [IDX_W-1:0]     rd_idx,
    input  logic                 owner,
    input  logic                 in_reset,
    output logic [DW-1:0]        rd_data
);

    logic [DW-1:0] dw_arr [NUM_DW];

    for (genvar g = 0; g < NUM_DW; g++) begin : g_unpack
        assign dw_arr[g] = win_flat[g*DW +: DW];
    end

    always_comb begin
        rd_data = dw_arr[rd_idx];
        if (rd_idx == IDX_W'(HDR_IDX)) begin
            rd_data[DW-1] = owner;
        end
        if (in_reset) begin
            rd_data = '1;
        end
    end

endmodule

// File: rtl/mailbox_shm.sv
module mailbox_shm
    import mbx_pkg::*;
#(
    parameter int unsigned NUM_DW = 8,
    parameter int unsigned DW     = 32,
    localparam int unsigned IDX_W = $clog2(NUM_DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             func_reset,
    input  logic             req_wr_en,
    input  logic [IDX_W-1:0] req_wr_idx,
    input  logic [DW-1:0]    req_wr_data,
    input  logic [IDX_W-1:0] req_rd_idx,
    output logic [DW-1:0]    req_rd_data,
    input  logic             rsp_wr_en,
    input  logic [DW-1:0]    rsp_wr_data,
    input  logic [IDX_W-1:0] rsp_rd_idx,
    output logic [DW-1:0]    rsp_rd_data,
    output logic             rsp_owns
);

    localparam int unsigned HDR_IDX = NUM_DW - 1;
    localparam int unsigned OWN_BIT = DW - 1;

    own_state_e            state;
    logic                  owner;
    logic                  in_reset;
    logic                  req_may_write;
    logic                  rsp_may_write;
    logic                  req_acc;
    logic                  rsp_acc;
    logic                  handover;
    logic                  release_req;
    logic                  st_wr_en;
    logic [IDX_W-1:0]      st_wr_idx;
    logic [DW-1:0]         st_wr_data;
    logic [NUM_DW*DW-1:0]  win_flat;

    // Write arbitration: only the current owner's write is accepted.
    always_comb begin
        req_acc     = req_wr_en && req_may_write;
        rsp_acc     = rsp_wr_en && rsp_may_write;
        handover    = req_acc && (req_wr_idx == IDX_W'(HDR_IDX));
        release_req = rsp_acc && !rsp_wr_data[OWN_BIT];
        st_wr_en    = req_acc || rsp_acc;
        st_wr_idx   = rsp_acc ? IDX_W'(HDR_IDX) : req_wr_idx;
        st_wr_data  = rsp_acc ? rsp_wr_data : req_wr_data;
    end

    mbx_own_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .func_reset    (func_reset),
        .handover      (handover),
        .release_req   (release_req),
        .state         (state),
        .owner         (owner),
        .in_reset      (in_reset),
        .req_may_write (req_may_write),
        .rsp_may_write (rsp_may_write)
    );

    mbx_store #(.NUM_DW(NUM_DW), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (func_reset),
        .wr_en    (st_wr_en),
        .wr_idx   (st_wr_idx),
        .wr_data  (st_wr_data),
        .win_flat (win_flat)
    );

    mbx_rd_port #(.NUM_DW(NUM_DW), .DW(DW)) u_rd_req (
        .win_flat (win_flat),
        .rd_idx   (req_rd_idx),
        .owner    (owner),
        .in_reset (in_reset),
        .rd_data  (req_rd_data)
    );

    mbx_rd_port #(.NUM_DW(NUM_DW), .DW(DW)) u_rd_rsp (
        .win_flat (win_flat),
        .rd_idx   (rsp_rd_idx),
        .owner    (owner),
        .in_reset (in_reset),
        .rd_data  (rsp_rd_data)
    );

    assign rsp_owns = owner;

endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
    parameter int unsigned NUM_DW = 8,
    parameter int unsigned DW     = 32,
    localparam int unsigned IDX_W = $clog2(NUM_DW)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 func_reset,
    input logic                 in_reset,
    input logic                 req_wr_en,
    input logic [IDX_W-1:0]     req_wr_idx,
    input logic                 rsp_wr_en,
    input logic [DW-1:0]        rsp_wr_data,
    input logic [DW-1:0]        req_rd_data,
    input logic [DW-1:0]        rsp_rd_data,
    input logic                 rsp_owns,
    input logic [NUM_DW*DW-1:0] win_flat
);

    localparam logic [IDX_W-1:0] HDR = IDX_W'(NUM_DW - 1);

    a_r3_hdr_write_hands_over: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_owns && !in_reset && req_wr_en && (req_wr_idx == HDR)) |=> rsp_owns);

    a_r4_req_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_owns && !in_reset && req_wr_en && !rsp_wr_en)
        |=> ($stable(win_flat) && rsp_owns));

    a_r5_rsp_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_owns && !in_reset && rsp_wr_en && !req_wr_en) |=> $stable(win_flat));

    a_r6_release_on_clear_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_owns && !in_reset && rsp_wr_en && !rsp_wr_data[DW-1]) |=> !rsp_owns);

    a_r7_keep_on_set_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_owns && !in_reset && rsp_wr_en && rsp_wr_data[DW-1]) |=> rsp_owns);

    a_r8_reads_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        in_reset |-> ((req_rd_data == '1) && (rsp_rd_data == '1)));

    a_r9_fn_reset_wipes: assert property (@(posedge clk) disable iff (!rst_n)
        func_reset |=> (!rsp_owns && (win_flat == '0)));

endmodule

bind mailbox_shm mbx_chk #(.NUM_DW(NUM_DW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .func_reset  (func_reset),
    .in_reset    (in_reset),
    .req_wr_en   (req_wr_en),
    .req_wr_idx  (req_wr_idx),
    .rsp_wr_en   (rsp_wr_en),
    .rsp_wr_data (rsp_wr_data),
    .req_rd_data (req_rd_data),
    .rsp_rd_data (rsp_rd_data),
    .rsp_owns    (rsp_owns),
    .win_flat    (win_flat)
);

// File: tb/mailbox_shm_tb.sv
module mailbox_shm_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        func_reset = 1'b0;
    logic        req_wr_en = 1'b0;
    logic [2:0]  req_wr_idx = '0;
    logic [31:0] req_wr_data = '0;
    logic [2:0]  req_rd_idx = '0;
    logic [31:0] req_rd_data;
    logic        rsp_wr_en = 1'b0;
    logic [31:0] rsp_wr_data = '0;
    logic [2:0]  rsp_rd_idx = '0;
    logic [31:0] rsp_rd_data;
    logic        rsp_owns;

    int unsigned n_chk = 0;
    int unsigned n_err = 0;

    logic [31:0] model [8];
    logic        own_m = 1'b0;

    always #4 clk = ~clk;

    mailbox_shm u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .func_reset  (func_reset),
        .req_wr_en   (req_wr_en),
        .req_wr_idx  (req_wr_idx),
        .req_wr_data (req_wr_data),
        .req_rd_idx  (req_rd_idx),
        .req_rd_data (req_rd_data),
        .rsp_wr_en   (rsp_wr_en),
        .rsp_wr_data (rsp_wr_data),
        .rsp_rd_idx  (rsp_rd_idx),
        .rsp_rd_data (rsp_rd_data),
        .rsp_owns    (rsp_owns)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic req_write(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        req_wr_en = 1'b1; req_wr_idx = idx; req_wr_data = d;
        @(negedge clk);
        req_wr_en = 1'b0;
    endtask

    task automatic rsp_write(input logic [31:0] d);
        @(negedge clk);
        rsp_wr_en = 1'b1; rsp_wr_data = d;
        @(negedge clk);
        rsp_wr_en = 1'b0;
    endtask

    function automatic logic [31:0] expect_dw(input int i);
        logic [31:0] v;
        v = model[i];
        if (i == 7) v[31] = own_m;
        return v;
    endfunction

    // Reads every dword on both ports and compares with the model.
    task automatic check_window(input string tag);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            req_rd_idx = 3'(i);
            rsp_rd_idx = 3'(7 - i);
            #1;
            chk({tag, " req port"}, req_rd_data, expect_dw(i));
            chk({tag, " rsp port"}, rsp_rd_data, expect_dw(7 - i));
        end
        chk({tag, " owner"}, {31'd0, rsp_owns}, {31'd0, own_m});
    endtask

    task automatic check_all_ones(input string tag);
        for (int i = 0; i < 8; i++) begin
            req_rd_idx = 3'(i);
            rsp_rd_idx = 3'(i);
            #1;
            chk({tag, " req port"}, req_rd_data, 32'hFFFF_FFFF);
            chk({tag, " rsp port"}, rsp_rd_data, 32'hFFFF_FFFF);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_window("R1");

        // R2: payload sweep, three patterns over dwords 0..6
        for (int p = 0; p < 3; p++) begin
            for (int i = 0; i < 7; i++) begin
                logic [31:0] v;
                v = (32'h1357_9BDF * (p + 1)) ^ (32'h0101_0101 * i) ^ (32'(p) << 28);
                req_write(3'(i), v);
                model[i] = v;
            end
            check_window("R2");
        end

        // R3: establish request header (kind 1, version 0, direction 0,
        // status 0, reset request flag set), bit 31 written as 0
        req_write(3'd7, 32'h0100_0001);
        model[7] = 32'h0100_0001;
        own_m    = 1'b1;
        check_window("R3");

        // R4: requester writes while responder owns are ignored
        req_write(3'd0, 32'hDEAD_BEEF);
        req_write(3'd7, 32'h0000_0002);
        check_window("R4");

        // R7: responder sweeps all status values with owner bit kept at 1
        for (int s = 0; s < 256; s++) begin
            logic [31:0] h;
            h = 32'h8000_0081 | (32'(s) << 8);
            rsp_write(h);
            model[7] = h;
            rsp_rd_idx = 3'd7;
            #1;
            chk("R7 header", rsp_rd_data, {1'b1, h[30:0]});
            chk("R7 owner", {31'd0, rsp_owns}, 32'd1);
        end

        // R6: success response with owner bit clear returns ownership
        rsp_write(32'h0000_0081);
        model[7] = 32'h0000_0081;
        own_m    = 1'b0;
        check_window("R6");

        // R5: responder write while requester owns is ignored
        rsp_write(32'h8000_FF82);
        check_window("R5");

        // Destroy request, then both sides write in the same cycle:
        // only the responder (owner) write lands
        req_write(3'd7, 32'h0000_0002);
        model[7] = 32'h0000_0002;
        own_m    = 1'b1;
        check_window("R3 destroy");
        @(negedge clk);
        req_wr_en = 1'b1; req_wr_idx = 3'd0; req_wr_data = 32'h1234_5678;
        rsp_wr_en = 1'b1; rsp_wr_data = 32'h0000_0182;
        @(negedge clk);
        req_wr_en = 1'b0; rsp_wr_en = 1'b0;
        model[7] = 32'h0000_0182;
        own_m    = 1'b0;
        check_window("R4 collision");

        // R8: function reset forces all-ones reads, writes ignored
        @(negedge clk);
        func_reset = 1'b1;
        check_all_ones("R8 asserted");
        req_write(3'd2, 32'hAAAA_5555);
        rsp_write(32'h0000_0000);
        @(negedge clk);
        check_all_ones("R8 held");
        chk("R8 owner", {31'd0, rsp_owns}, 32'd0);
        @(negedge clk);
        func_reset = 1'b0;
        req_rd_idx = 3'd7;
        rsp_rd_idx = 3'd1;
        #1;
        chk("R8 exit cycle req", req_rd_data, 32'hFFFF_FFFF);
        chk("R8 exit cycle rsp", rsp_rd_data, 32'hFFFF_FFFF);

        // R9: after exit, window is zero and requester owns it again
        for (int i = 0; i < 8; i++) model[i] = '0;
        own_m = 1'b0;
        check_window("R9");
        req_write(3'd3, 32'h0F0F_F0F0);
        model[3] = 32'h0F0F_F0F0;
        check_window("R9 write after exit");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule